// File: doc/BRIEF.md
# Timer Output Compare Reference Generator

This block is one compare channel of a general-purpose timer. A 16-bit counter advances once every (prescaler + 1) clocks while running and counts either up or down between zero and a programmable reload limit. Each time the counter lands on a new value, that value is compared with a 16-bit compare value. A 3-bit mode field then sets how the compare drives a single reference waveform. The modes are: hold, set on match, clear on match, toggle on match, force low, force high, and two pulse-width modes whose rule depends on the counting direction.

A match also sets a sticky flag. The flag stays set until software writes a one to clear it. Two outputs, an interrupt and a DMA request, are the flag gated by their own enable bits. Configuration arrives on a write-only port made of a write strobe, an address and a data word. The counter value is driven out so that the channel can also serve as a plain time base.

Top module: `oc_ref_gen`

## Requirements
- R1: While the run bit is set (bit 0 at address 0), the counter changes once every (prescaler + 1) clocks, where the prescaler is at address 1. The first change comes prescaler + 1 clocks after the write that sets the run bit. While the run bit is clear, the counter holds its value.
- R2: When bit 1 at address 0 is clear (counting up), the counter goes 0, 1, … up to the reload value at address 2, and then returns to 0.
- R3: When bit 1 at address 0 is set (counting down), the counter decrements. From 0 it reloads to the reload value. From reset it starts at 0, so its first step goes to the reload value.
- R4: A match event occurs once, in the clock after the counter steps onto the compare value at address 3. A match event sets the flag. Writing data with bit 0 set to address 5 clears the flag. Writing a 0 there has no effect. If a match and a clear fall in the same clock, the match wins.
- R5: Mode 0 (bits 2:0 at address 4): a match leaves the reference unchanged, and the counter keeps running.
- R6: Mode 1 drives the reference high on a match event. Mode 2 drives it low on a match event.
- R7: Mode 3 inverts the reference on every match event.
- R8: Mode 4 holds the reference low and mode 5 holds it high, whatever the counter does.
- R9: Mode 6 works as follows. Counting up, the reference is high while counter < compare and low otherwise. Counting down, it is low while counter > compare and high otherwise. The reference follows the counter one clock later.
- R10: Mode 7 gives the inverse of mode 6 in both directions.
- R11: The interrupt output equals flag AND bit 3 at address 4. The DMA request equals flag AND bit 4 at address 4. Both enables reset to disabled.
- R12: After reset, the counter is 0, the reference is low, the flag is clear, and the channel is stopped, counting up, in mode 0, with prescaler 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 16 | Register write data |
| cntVal | output | 16 | Current counter value |
| ocRef | output | 1 | Reference waveform |
| matchFlag | output | 1 | Sticky compare-match flag |
| irqOut | output | 1 | Interrupt request |
| dmaReq | output | 1 | DMA request |

## Verification
The hardest case to reach is a second match event in toggle mode. It needs a full counter period to go by, and the counter position must be known exactly at the end. The bench gets there by resetting the channel, starting it with a zero prescaler, and waiting exactly one period plus the compare offset. This shows the reference inverting once per arrival and not once per clock.

The clear-on-match mode has a similar problem, because it needs a high reference before the match. The stimulus reaches that state by first selecting force-high while the counter is stopped, then switching to clear mode before the run bit is set.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic [2:0] {
    MODE_FROZEN = 3'd0,
    MODE_SET    = 3'd1,
    MODE_CLR    = 3'd2,
    MODE_TOG    = 3'd3,
    MODE_FLO    = 3'd4,
    MODE_FHI    = 3'd5,
    MODE_PWM1   = 3'd6,
    MODE_PWM2   = 3'd7
  } ocMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;       // counter advances this clock
    logic clrFlag;    // software clear of the match flag
    logic countDown;  // direction of counting
  } dpStrobe_t;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_PRESC  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_RELOAD = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CMP    = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_MODE   = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_FLAG   = 3'd5;

endpackage

// File: rtl/oc_ctrl.sv
module oc_ctrl
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output dpStrobe_t         strobe,
  output ocMode_t           cfgMode,
  output logic [CNT_W-1:0]  cfgReload,
  output logic [CNT_W-1:0]  cfgCmp,
  output logic              irqEn,
  output logic              dmaEn
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             runEn;
  logic             dirDown;
  logic [CNT_W-1:0] cfgPresc;
  logic [CNT_W-1:0] presCnt;
  logic             tick;

  // register file
  always_ff @(posedge clk) begin
    if (rst) begin
      runEn     <= 1'b0;
      dirDown   <= 1'b0;
      cfgPresc  <= '0;
      cfgReload <= '1;
      cfgCmp    <= '0;
      cfgMode   <= MODE_FROZEN;
      irqEn     <= 1'b0;
      dmaEn     <= 1'b0;
    end else if (wrEn) begin
      case (wrAddr)
        ADR_CTRL: begin
          runEn   <= wrData[0];
          dirDown <= wrData[1];
        end
        ADR_PRESC:  cfgPresc  <= wrData;
        ADR_RELOAD: cfgReload <= wrData;
        ADR_CMP:    cfgCmp    <= wrData;
        ADR_MODE: begin
          cfgMode <= ocMode_t'(wrData[2:0]);
          irqEn   <= wrData[3];
          dmaEn   <= wrData[4];
        end
        default: ;
      endcase
    end
  end

  // prescaler: one tick every cfgPresc+1 clocks while running
  assign tick = runEn && (presCnt >= cfgPresc);

  always_ff @(posedge clk) begin
    if (rst || !runEn) begin
      presCnt <= '0;
    end else if (tick) begin
      presCnt <= '0;
    end else begin
      presCnt <= presCnt + ONE;
    end
  end

  always_comb begin
    strobe.tick      = tick;
    strobe.clrFlag   = wrEn && (wrAddr == ADR_FLAG) && wrData[0];
    strobe.countDown = dirDown;
  end

  // R1: prescaler never runs while stopped
  assert_presc_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !runEn |=> (presCnt == '0));

endmodule

// File: rtl/oc_dp.sv
module oc_dp
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        strobe,
  input  ocMode_t          cfgMode,
  input  logic [CNT_W-1:0] cfgReload,
  input  logic [CNT_W-1:0] cfgCmp,
  output logic [CNT_W-1:0] cntVal,
  output logic             ocRef,
  output logic             matchFlag
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic moved;   // counter stepped in the previous clock
  logic hitNow;  // match event
  logic refNext;
  logic belowCmp;
  logic aboveCmp;

  // counter
  always_ff @(posedge clk) begin
    if (rst) begin
      cntVal <= '0;
      moved  <= 1'b0;
    end else begin
      moved <= strobe.tick;
      if (strobe.tick) begin
        if (strobe.countDown) begin
          cntVal <= (cntVal == '0) ? cfgReload : cntVal - ONE;
        end else begin
          cntVal <= (cntVal >= cfgReload) ? '0 : cntVal + ONE;
        end
      end
    end
  end

  assign hitNow   = moved && (cntVal == cfgCmp);
  assign belowCmp = cntVal < cfgCmp;
  assign aboveCmp = cntVal > cfgCmp;

  // reference next-state
  always_comb begin
    refNext = ocRef;
    case (cfgMode)
      MODE_FROZEN: refNext = ocRef;
      MODE_SET:    if (hitNow) refNext = 1'b1;
      MODE_CLR:    if (hitNow) refNext = 1'b0;
      MODE_TOG:    if (hitNow) refNext = !ocRef;
      MODE_FLO:    refNext = 1'b0;
      MODE_FHI:    refNext = 1'b1;
      MODE_PWM1:   refNext = strobe.countDown ? !aboveCmp : belowCmp;
      MODE_PWM2:   refNext = strobe.countDown ? aboveCmp : !belowCmp;
      default:     refNext = ocRef;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ocRef     <= 1'b0;
      matchFlag <= 1'b0;
    end else begin
      ocRef <= refNext;
      if (hitNow) begin
        matchFlag <= 1'b1;
      end else if (strobe.clrFlag) begin
        matchFlag <= 1'b0;
      end
    end
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !strobe.tick |=> $stable(cntVal));

  assert_up_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (strobe.tick && !strobe.countDown && (cntVal >= cfgReload)) |=> (cntVal == '0));

  assert_down_reload_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe.tick && strobe.countDown && (cntVal == '0)) |=> (cntVal == $past(cfgReload)));

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (rst)
    hitNow |=> matchFlag);

  assert_toggle_R7: assert property (@(posedge clk) disable iff (rst)
    (cfgMode == MODE_TOG && hitNow) |=> (ocRef != $past(ocRef)));

  assert_force_hi_R8: assert property (@(posedge clk) disable iff (rst)
    (cfgMode == MODE_FHI) |=> ocRef);

  assert_force_lo_R8: assert property (@(posedge clk) disable iff (rst)
    (cfgMode == MODE_FLO) |=> !ocRef);

endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  cntVal,
  output logic              ocRef,
  output logic              matchFlag,
  output logic              irqOut,
  output logic              dmaReq
);

  dpStrobe_t        strobe;
  ocMode_t          cfgMode;
  logic [CNT_W-1:0] cfgReload;
  logic [CNT_W-1:0] cfgCmp;
  logic             irqEn;
  logic             dmaEn;

  oc_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .cfgMode(cfgMode), .cfgReload(cfgReload),
    .cfgCmp(cfgCmp), .irqEn(irqEn), .dmaEn(dmaEn)
  );

  oc_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rst(rst), .strobe(strobe), .cfgMode(cfgMode),
    .cfgReload(cfgReload), .cfgCmp(cfgCmp),
    .cntVal(cntVal), .ocRef(ocRef), .matchFlag(matchFlag)
  );

  // R11: requests gated by their enables
  assign irqOut = matchFlag && irqEn;
  assign dmaReq = matchFlag && dmaEn;

  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (rst)
    irqOut |-> matchFlag);

endmodule

// File: tb/tb_oc_ref_gen.sv
module tb_oc_ref_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] cntVal;
  logic        ocRef, matchFlag, irqOut, dmaReq;

  int checks = 0;
  int errors = 0;

  always #10 clk = !clk;  // 50 MHz

  oc_ref_gen dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cntVal(cntVal), .ocRef(ocRef), .matchFlag(matchFlag),
    .irqOut(irqOut), .dmaReq(dmaReq)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic        down;
    logic [15:0] presc;
    logic [15:0] reload;
    logic [15:0] cmp;
    logic [15:0] n;
    logic [15:0] expCnt;
    logic        expRef;
    logic        expFlag;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VT [NV] = '{
    '{3'd6, 1'b0, 16'd0, 16'd9, 16'd4, 16'd3,  16'd3, 1'b1, 1'b0}, // R9 R2
    '{3'd6, 1'b0, 16'd0, 16'd9, 16'd4, 16'd7,  16'd7, 1'b0, 1'b1}, // R9 R4
    '{3'd6, 1'b0, 16'd0, 16'd9, 16'd4, 16'd5,  16'd5, 1'b0, 1'b1}, // R9 equal
    '{3'd7, 1'b0, 16'd0, 16'd9, 16'd4, 16'd7,  16'd7, 1'b1, 1'b1}, // R10
    '{3'd7, 1'b0, 16'd0, 16'd9, 16'd4, 16'd3,  16'd3, 1'b0, 1'b0}, // R10
    '{3'd6, 1'b1, 16'd0, 16'd9, 16'd4, 16'd3,  16'd7, 1'b0, 1'b0}, // R9 R3
    '{3'd6, 1'b1, 16'd0, 16'd9, 16'd4, 16'd8,  16'd2, 1'b1, 1'b1}, // R9 down
    '{3'd6, 1'b1, 16'd0, 16'd9, 16'd4, 16'd7,  16'd3, 1'b1, 1'b1}, // R9 down equal
    '{3'd7, 1'b1, 16'd0, 16'd9, 16'd4, 16'd8,  16'd2, 1'b0, 1'b1}, // R10 down
    '{3'd7, 1'b1, 16'd0, 16'd9, 16'd4, 16'd3,  16'd7, 1'b1, 1'b0}, // R10 down
    '{3'd1, 1'b0, 16'd0, 16'd9, 16'd4, 16'd5,  16'd5, 1'b1, 1'b1}, // R6 set
    '{3'd1, 1'b0, 16'd0, 16'd9, 16'd4, 16'd4,  16'd4, 1'b0, 1'b0}, // R6 before match
    '{3'd2, 1'b0, 16'd0, 16'd9, 16'd4, 16'd5,  16'd5, 1'b0, 1'b1}, // R6 clear
    '{3'd3, 1'b0, 16'd0, 16'd9, 16'd4, 16'd5,  16'd5, 1'b1, 1'b1}, // R7 first
    '{3'd3, 1'b0, 16'd0, 16'd9, 16'd4, 16'd14, 16'd4, 1'b1, 1'b1}, // R7 before second
    '{3'd3, 1'b0, 16'd0, 16'd9, 16'd4, 16'd15, 16'd5, 1'b0, 1'b1}, // R7 second
    '{3'd0, 1'b0, 16'd0, 16'd9, 16'd4, 16'd7,  16'd7, 1'b0, 1'b1}, // R5
    '{3'd5, 1'b0, 16'd0, 16'd9, 16'd4, 16'd2,  16'd2, 1'b1, 1'b0}, // R8 high
    '{3'd4, 1'b0, 16'd0, 16'd9, 16'd4, 16'd7,  16'd7, 1'b0, 1'b1}, // R8 low
    '{3'd6, 1'b0, 16'd2, 16'd9, 16'd1, 16'd8,  16'd2, 1'b0, 1'b1}, // R1
    '{3'd6, 1'b0, 16'd2, 16'd9, 16'd1, 16'd9,  16'd3, 1'b0, 1'b1}, // R1
    '{3'd6, 1'b0, 16'd2, 16'd9, 16'd1, 16'd2,  16'd0, 1'b1, 1'b0}, // R1 no step yet
    '{3'd6, 1'b0, 16'd0, 16'd3, 16'd0, 16'd4,  16'd0, 1'b0, 1'b0}, // R2 wrap
    '{3'd6, 1'b0, 16'd0, 16'd3, 16'd0, 16'd5,  16'd1, 1'b0, 1'b1}, // R2 after wrap
    '{3'd6, 1'b1, 16'd0, 16'd3, 16'd0, 16'd5,  16'd3, 1'b1, 1'b1}  // R3 reload
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic runVec(input vec_t v);
    doReset();
    wr(3'd1, v.presc);
    wr(3'd2, v.reload);
    wr(3'd3, v.cmp);
    wr(3'd4, {13'd0, v.mode});
    wr(3'd0, {14'd0, v.down, 1'b1});
    repeat (int'(v.n)) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] held;
    doReset();
    // R12 reset state
    check("R12 cnt", cntVal, 16'd0);
    check("R12 ref", {15'd0, ocRef}, 16'd0);
    check("R12 flag", {15'd0, matchFlag}, 16'd0);
    check("R11 irq reset", {15'd0, irqOut}, 16'd0);
    check("R11 dma reset", {15'd0, dmaReq}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      runVec(VT[i]);
      check($sformatf("vec %0d cnt", i), cntVal, VT[i].expCnt);
      check($sformatf("vec %0d ref", i), {15'd0, ocRef}, {15'd0, VT[i].expRef});
      check($sformatf("vec %0d flag", i), {15'd0, matchFlag}, {15'd0, VT[i].expFlag});
    end

    // R1 hold when stopped, R11 gating, R4 clear
    runVec(VT[1]);
    check("R11 irq disabled", {15'd0, irqOut}, 16'd0);
    check("R11 dma disabled", {15'd0, dmaReq}, 16'd0);
    wr(3'd0, 16'd0);
    check("R1 last step", cntVal, 16'd8);
    held = cntVal;
    repeat (5) @(negedge clk);
    check("R1 held", cntVal, held);
    wr(3'd4, 16'd6 | 16'h0008);
    check("R11 irq on", {15'd0, irqOut}, 16'd1);
    check("R11 dma off", {15'd0, dmaReq}, 16'd0);
    wr(3'd4, 16'd6 | 16'h0010);
    check("R11 irq off", {15'd0, irqOut}, 16'd0);
    check("R11 dma on", {15'd0, dmaReq}, 16'd1);
    wr(3'd5, 16'd0);
    check("R4 zero write keeps flag", {15'd0, matchFlag}, 16'd1);
    wr(3'd5, 16'd1);
    check("R4 cleared", {15'd0, matchFlag}, 16'd0);
    check("R11 dma follows clear", {15'd0, dmaReq}, 16'd0);

    // R6 clear on match from a high reference
    doReset();
    wr(3'd2, 16'd9);
    wr(3'd3, 16'd4);
    wr(3'd4, 16'd5);
    wr(3'd4, 16'd2);
    check("R6 preset high", {15'd0, ocRef}, 16'd1);
    wr(3'd0, 16'd1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R6 high before match", {15'd0, ocRef}, 16'd1);
    @(negedge clk);
    check("R6 low after match", {15'd0, ocRef}, 16'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule